// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block behaves like a three-wire serial EEPROM of the Microwire kind. A host raises chip select, toggles the serial clock and shifts in a start bit, a two-bit opcode, an address and, for writes, a data word. The block decodes read, write, single-word erase, whole-array erase, whole-array write, and the two commands that open and close the program-enable latch, and it carries them out on an internal byte array. A strap input chooses between 8-bit and 16-bit words.

All pins are sampled by a fast system clock through a parameterized synchronizer, so the block sits inside a synchronous design. Programming is modelled by a busy timer counted in system-clock cycles. While the timer runs, the data-out pin reports progress whenever chip select is high. The power-on reset input stands in for a supply-threshold lockout. The array keeps its contents across resets.

Top module: `mw_eeprom`

## Requirements
- R1: While chip select is high, a frame begins only at the first serial-clock rise that samples data-in high. Rises that sample data-in low before that point have no effect and leave data-out released.
- R2: With the strap high, words are 16 bits wide and take ADDR_W-1 address bits, and word w is the pair {byte 2w+1, byte 2w}. With the strap low, each byte is addressed by ADDR_W bits. The strap is sampled when the start bit arrives.
- R3: After the start bit, two opcode bits are sent first-bit-first: 10 read, 01 write, 11 erase. For 00, the two most significant address bits select the command: 11 enables programming, 00 disables it, 10 erases the whole array, 01 writes the whole array.
- R4: A read drives a single zero bit on data-out after the last address rise. Each following rise presents the next data bit, most significant first. The rise after the last data bit releases data-out.
- R5: A write takes its data most significant bit first and stores it at the addressed word once the final data bit has been clocked in.
- R6: The program-enable latch is clear after reset. While it is clear, write, erase, erase-all and write-all change nothing and report no busy status. The enable and disable commands set and clear it. Reads work in either state.
- R7: Erase sets the addressed word to all ones. Erase-all sets every byte to all ones. Write-all stores its data word at every word address.
- R8: Each accepted programming command holds the block busy for BUSY_CYCLES system-clock cycles. With chip select high, data-out drives low while busy and high once ready. Start bits that arrive while busy are ignored.
- R9: Data-out is released whenever chip select is low, and whenever no read is in progress and no programming status is pending.
- R10: Lowering chip select before the last required bit of a frame aborts the frame, with no change to the array and no busy period.
- R11: Once a frame has completed, further clock and data activity is ignored until chip select goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low power-on reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data in |
| org_i | input | 1 | Word-size strap: 1 = 16-bit, 0 = 8-bit |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Data-out drive enable; 0 means high impedance |

## Verification
A pin change reaches the frame logic after the synchronizer stages plus one edge-detect register. Every decode step, read-data bit and release therefore appears on data-out three system clocks after the serial-clock rise that causes it. The bench holds each serial-clock phase for four system clocks and samples data-out at the end of the low phase, just before the next rise, so each sample sees the settled result of the previous rise. The busy period runs 300 cycles from the launching rise. The bench checks busy status on the first reconnect, which comes well inside that window, and then polls with a bound for the ready level.

// File: rtl/mw_pkg.sv
package mw_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_OPC,
      S_ADDR,
      S_DATA,
      S_RDOUT,
      S_DONE
   } mw_state_t;

   localparam logic [1:0] OP_READ  = 2'b10;
   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_ERASE = 2'b11;
   localparam logic [1:0] OP_EXT   = 2'b00;

   localparam logic [1:0] EX_ENABLE  = 2'b11;
   localparam logic [1:0] EX_DISABLE = 2'b00;
   localparam logic [1:0] EX_CLRALL  = 2'b10;
   localparam logic [1:0] EX_FILLALL = 2'b01;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
   parameter int STAGES = 2,
   parameter int W      = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_direct
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
            end else begin
               pipe[0] <= d_i;
               for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
            end
         end
         assign q_o = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/mw_busy.sv
module mw_busy #(
   parameter int CYC = 2000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   output logic busy_o
);

   localparam int CW = $clog2(CYC + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (go_i)         cnt <= CW'(CYC);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign busy_o = (cnt != '0);

   assert_busy_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(go_i));

   assert_busy_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !go_i) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/mw_store.sv
module mw_store #(
   parameter int AW = 11
) (
   input  logic          clk,
   input  logic          wr_i,
   input  logic          all_i,
   input  logic          wide_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [15:0]   wdata_i,
   input  logic [AW-1:0] raddr_i,
   input  logic          rwide_i,
   output logic [15:0]   rdata_o
);

   localparam int NB = 1 << AW;

   logic [7:0] mem [NB];

   always_ff @(posedge clk) begin
      if (wr_i) begin
         if (all_i) begin
            for (int i = 0; i < NB; i++)
               mem[i] <= (wide_i && i[0]) ? wdata_i[15:8] : wdata_i[7:0];
         end else if (wide_i) begin
            mem[{waddr_i[AW-2:0], 1'b0}] <= wdata_i[7:0];
            mem[{waddr_i[AW-2:0], 1'b1}] <= wdata_i[15:8];
         end else begin
            mem[waddr_i] <= wdata_i[7:0];
         end
      end
   end

   always_comb begin
      if (rwide_i) rdata_o = {mem[{raddr_i[AW-2:0], 1'b1}], mem[{raddr_i[AW-2:0], 1'b0}]};
      else         rdata_o = {8'h00, mem[raddr_i]};
   end

endmodule

// File: rtl/mw_frame.sv
module mw_frame
   import mw_pkg::*;
#(
   parameter int AW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_s,
   input  logic          sk_rise,
   input  logic          di_s,
   input  logic          org_s,
   input  logic          busy_i,
   input  logic [15:0]   rd_data_i,
   output logic [AW-1:0] rd_addr_o,
   output logic          rd_wide_o,
   output logic          go_o,
   output logic          all_o,
   output logic          wide_o,
   output logic [AW-1:0] addr_o,
   output logic [15:0]   data_o,
   output logic          do_o,
   output logic          do_oe
);

   localparam int CW = $clog2(((AW > 16) ? AW : 16) + 1);

   mw_state_t     state;
   logic [1:0]    op;
   logic [CW-1:0] cnt;
   logic [AW-1:0] addr_q;
   logic [14:0]   data_sr;
   logic [15:0]   rd_sr;
   logic          out_bit;
   logic          wide;
   logic          wen;
   logic          stat_en;

   logic [AW-1:0] addr_nx;
   logic [15:0]   data_nx;
   logic [1:0]    ext;
   logic [CW-1:0] aw_last;
   logic [CW-1:0] dw_last;
   logic [CW-1:0] dw_n;
   logic          step;

   assign step    = cs_s && sk_rise;
   assign addr_nx = {addr_q[AW-2:0], di_s};
   assign data_nx = {data_sr, di_s};
   assign ext     = wide ? addr_nx[AW-2 -: 2] : addr_nx[AW-1 -: 2];
   assign aw_last = wide ? CW'(AW - 2) : CW'(AW - 1);
   assign dw_last = wide ? CW'(15) : CW'(7);
   assign dw_n    = wide ? CW'(16) : CW'(8);

   assign rd_addr_o = addr_nx;
   assign rd_wide_o = wide;
   assign wide_o    = wide;

   always_comb begin
      go_o   = 1'b0;
      all_o  = 1'b0;
      addr_o = addr_q;
      data_o = data_nx;
      if (step && wen) begin
         if (state == S_ADDR && cnt == aw_last) begin
            if (op == OP_ERASE) begin
               go_o   = 1'b1;
               addr_o = addr_nx;
               data_o = 16'hFFFF;
            end else if (op == OP_EXT && ext == EX_CLRALL) begin
               go_o   = 1'b1;
               all_o  = 1'b1;
               data_o = 16'hFFFF;
            end
         end else if (state == S_DATA && cnt == dw_last) begin
            go_o  = 1'b1;
            all_o = (op == OP_EXT);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         op      <= '0;
         cnt     <= '0;
         addr_q  <= '0;
         data_sr <= '0;
         rd_sr   <= '0;
         out_bit <= 1'b0;
         wide    <= 1'b0;
         wen     <= 1'b0;
         stat_en <= 1'b0;
      end else if (!cs_s) begin
         state <= S_IDLE;
      end else if (sk_rise) begin
         unique case (state)
            S_IDLE: begin
               if (di_s && !busy_i) begin
                  state   <= S_OPC;
                  op      <= '0;
                  cnt     <= '0;
                  addr_q  <= '0;
                  data_sr <= '0;
                  wide    <= org_s;
                  stat_en <= 1'b0;
               end
            end
            S_OPC: begin
               op  <= {op[0], di_s};
               cnt <= cnt + 1'b1;
               if (cnt == CW'(1)) begin
                  state <= S_ADDR;
                  cnt   <= '0;
               end
            end
            S_ADDR: begin
               addr_q <= addr_nx;
               cnt    <= cnt + 1'b1;
               if (cnt == aw_last) begin
                  cnt <= '0;
                  unique case (op)
                     OP_READ: begin
                        rd_sr   <= wide ? rd_data_i : {rd_data_i[7:0], 8'h00};
                        out_bit <= 1'b0;
                        state   <= S_RDOUT;
                     end
                     OP_WRITE: state <= S_DATA;
                     OP_ERASE: state <= S_DONE;
                     default: begin
                        unique case (ext)
                           EX_ENABLE:  begin wen <= 1'b1; state <= S_DONE; end
                           EX_DISABLE: begin wen <= 1'b0; state <= S_DONE; end
                           EX_CLRALL:  state <= S_DONE;
                           default:    state <= S_DATA;
                        endcase
                     end
                  endcase
               end
            end
            S_DATA: begin
               data_sr <= data_nx[14:0];
               cnt     <= cnt + 1'b1;
               if (cnt == dw_last) state <= S_DONE;
            end
            S_RDOUT: begin
               if (cnt == dw_n) begin
                  state <= S_DONE;
               end else begin
                  out_bit <= rd_sr[15];
                  rd_sr   <= {rd_sr[14:0], 1'b0};
                  cnt     <= cnt + 1'b1;
               end
            end
            default: ;
         endcase
         if (go_o) stat_en <= 1'b1;
      end
   end

   assign do_oe = cs_s && ((state == S_RDOUT) ||
                           (stat_en && (state == S_IDLE || state == S_DONE)));
   assign do_o  = (state == S_RDOUT) ? out_bit : !busy_i;

   assert_start_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state != S_IDLE && $past(state) == S_IDLE) |-> $past(sk_rise && di_s && cs_s && !busy_i));

   assert_latch_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wen) |-> $past(state == S_ADDR && op == OP_EXT));

   assert_go_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      go_o |-> !busy_i);

   assert_release_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_DONE && $past(state) == S_RDOUT) |-> !do_oe);

   assert_cs_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_s |=> (state == S_IDLE));

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
   parameter int ADDR_W      = 11,
   parameter int BUSY_CYCLES = 2000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_i,
   input  logic sk_i,
   input  logic di_i,
   input  logic org_i,
   output logic do_o,
   output logic do_oe_o
);

   generate
      if (ADDR_W < 3 || ADDR_W > 16) begin : g_bad_addr
         $error("mw_eeprom: ADDR_W must lie in 3..16");
      end
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("mw_eeprom: BUSY_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("mw_eeprom: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [3:0]        pins_s;
   logic              cs_s, sk_s, di_s, org_s, sk_q, sk_rise;
   logic              busy, go, all_w, wide;
   logic [ADDR_W-1:0] raddr, waddr;
   logic              rwide;
   logic [15:0]       rdata, wdata;

   mw_sync #(.STAGES(SYNC_STAGES), .W(4)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({cs_i, sk_i, di_i, org_i}),
      .q_o   (pins_s)
   );

   assign {cs_s, sk_s, di_s, org_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sk_q <= 1'b0;
      else        sk_q <= sk_s;
   end
   assign sk_rise = sk_s && !sk_q;

   mw_frame #(.AW(ADDR_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_s      (cs_s),
      .sk_rise   (sk_rise),
      .di_s      (di_s),
      .org_s     (org_s),
      .busy_i    (busy),
      .rd_data_i (rdata),
      .rd_addr_o (raddr),
      .rd_wide_o (rwide),
      .go_o      (go),
      .all_o     (all_w),
      .wide_o    (wide),
      .addr_o    (waddr),
      .data_o    (wdata),
      .do_o      (do_o),
      .do_oe     (do_oe_o)
   );

   mw_busy #(.CYC(BUSY_CYCLES)) u_busy (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (go),
      .busy_o (busy)
   );

   mw_store #(.AW(ADDR_W)) u_store (
      .clk     (clk),
      .wr_i    (go),
      .all_i   (all_w),
      .wide_i  (wide),
      .waddr_i (waddr),
      .wdata_i (wdata),
      .raddr_i (raddr),
      .rwide_i (rwide),
      .rdata_o (rdata)
   );

endmodule

// File: tb/sim_mw_eeprom.sv
module sim_mw_eeprom;

   localparam int AWB  = 6;
   localparam int NB   = 1 << AWB;
   localparam int NW   = NB / 2;
   localparam int BUSY = 300;
   localparam int HALF = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
   logic do_o, do_oe;

   int n_chk = 0;
   int n_err = 0;
   logic s_do, s_oe;
   logic wen_m = 1'b0;
   logic [7:0] mdl [NB];

   always #10 clk = ~clk;

   mw_eeprom #(.ADDR_W(AWB), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .org_i(org),
      .do_o(do_o), .do_oe_o(do_oe)
   );

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (ok !== 1'b1) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bitx(input logic d);
      di = d;
      tick(HALF);
      s_do = do_o;
      s_oe = do_oe;
      sk = 1'b1;
      tick(HALF);
      sk = 1'b0;
   endtask

   task automatic cs_up;
      cs = 1'b1;
      tick(HALF);
   endtask

   task automatic cs_dn;
      cs = 1'b0;
      di = 1'b0;
      tick(2 * HALF);
   endtask

   function automatic int awid();
      return org ? AWB - 1 : AWB;
   endfunction

   function automatic int dwid();
      return org ? 16 : 8;
   endfunction

   function automatic int ext_addr(input logic [1:0] c);
      return int'(c) << (awid() - 2);
   endfunction

   function automatic logic [15:0] exp_rd(input int a);
      if (org) return {mdl[2*a+1], mdl[2*a]};
      return {8'h00, mdl[a]};
   endfunction

   task automatic mdl_put(input int a, input logic [15:0] v);
      if (org) begin
         mdl[2*a]   = v[7:0];
         mdl[2*a+1] = v[15:8];
      end else begin
         mdl[a] = v[7:0];
      end
   endtask

   task automatic hdr(input logic [1:0] op, input int a);
      bitx(1'b1);
      bitx(op[1]);
      bitx(op[0]);
      for (int i = awid() - 1; i >= 0; i--) bitx(a[i]);
   endtask

   task automatic send_data(input logic [15:0] v);
      for (int i = dwid() - 1; i >= 0; i--) bitx(v[i]);
   endtask

   task automatic rd(input int a, output logic [15:0] v);
      v = '0;
      cs_up;
      hdr(2'b10, a);
      bitx(1'b0);
      chk(s_oe === 1'b1 && s_do === 1'b0, "R4 dummy zero", {s_oe, s_do}, 2'b10);
      for (int k = 0; k < dwid(); k++) begin
         bitx(1'b0);
         v = {v[14:0], s_do};
      end
      chk(do_oe === 1'b0, "R4/R9 release after last read bit", do_oe, 0);
      cs_dn;
   endtask

   task automatic rd_chk(input int a, input string req);
      logic [15:0] v;
      rd(a, v);
      chk(v === exp_rd(a), req, v, exp_rd(a));
   endtask

   task automatic wait_ready(input logic expect_busy, input string req);
      int k;
      cs_up;
      if (expect_busy) begin
         chk(do_oe === 1'b1 && do_o === 1'b0, {req, " busy low"}, {do_oe, do_o}, 2'b10);
         k = 0;
         while (do_o !== 1'b1 && k < 1000) begin
            tick(1);
            k++;
         end
         chk(k < 1000 && do_oe === 1'b1, {req, " ready high"}, {do_oe, do_o}, 2'b11);
      end else begin
         chk(do_oe === 1'b0, {req, " no busy status"}, do_oe, 0);
      end
      cs_dn;
   endtask

   task automatic ext_cmd(input logic [1:0] code);
      cs_up;
      hdr(2'b00, ext_addr(code));
      cs_dn;
   endtask

   task automatic wr(input int a, input logic [15:0] v, input string req);
      cs_up;
      hdr(2'b01, a);
      send_data(v);
      cs_dn;
      if (wen_m) mdl_put(a, v);
      wait_ready(wen_m, req);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      logic [15:0] v;
      tick(5);
      rst_n = 1'b1;
      tick(5);

      // R9: released after reset
      chk(do_oe === 1'b0, "R9 reset release", do_oe, 0);

      // R1: leading zero rises while selected start nothing
      cs_up;
      for (int i = 0; i < 5; i++) begin
         bitx(1'b0);
         chk(do_oe === 1'b0, "R1 zeros before start", do_oe, 0);
      end
      // R3: enable command follows leading zeros in the same selection
      hdr(2'b00, ext_addr(2'b11));
      cs_dn;
      wen_m = 1'b1;

      // R7/R3: erase-all
      ext_cmd(2'b10);
      for (int b = 0; b < NB; b++) mdl[b] = 8'hFF;
      wait_ready(1'b1, "R8 erase-all");
      for (int w = 0; w < NW; w++) rd_chk(w, "R7 erase-all ones");

      // R6: disabled latch blocks writes, reads still work
      ext_cmd(2'b00);
      wen_m = 1'b0;
      wr(3, 16'h1234, "R6 write while disabled");
      rd_chk(3, "R6 word unchanged while disabled");

      // R5: 16-bit write sweep
      ext_cmd(2'b11);
      wen_m = 1'b1;
      for (int w = 0; w < NW; w++)
         wr(w, 16'((w * 16'h0911) ^ 16'hA5C3), "R8 word write");
      for (int w = 0; w < NW; w++) rd_chk(w, "R5 word readback");

      // R2: byte view of the same array, then byte writes seen as words
      org = 1'b0;
      for (int b = 0; b < NB; b++) rd_chk(b, "R2 byte view");
      for (int b = 0; b < NB; b++) wr(b, 16'(8'(b * 37 + 11)), "R8 byte write");
      org = 1'b1;
      for (int w = 0; w < NW; w++) rd_chk(w, "R2 word view of bytes");

      // R7: single erase
      cs_up;
      hdr(2'b11, 5);
      cs_dn;
      mdl_put(5, 16'hFFFF);
      wait_ready(1'b1, "R8 erase");
      for (int w = 4; w < 7; w++) rd_chk(w, "R7 erase word");

      // R8: start bits ignored while busy
      cs_up;
      hdr(2'b01, 7);
      send_data(16'hBEEF);
      cs_dn;
      mdl_put(7, 16'hBEEF);
      cs_up;
      chk(do_oe === 1'b1 && do_o === 1'b0, "R8 busy on reconnect", {do_oe, do_o}, 2'b10);
      cs_dn;
      cs_up;
      hdr(2'b01, 9);
      send_data(16'h0F0F);
      chk(do_oe === 1'b1 && do_o === 1'b0, "R8 frame during busy ignored", {do_oe, do_o}, 2'b10);
      cs_dn;
      wait_ready(1'b1, "R8 busy wait");
      rd_chk(7, "R8 first write landed");
      rd_chk(9, "R8 write during busy dropped");

      // R10: abort mid-data
      cs_up;
      hdr(2'b01, 2);
      for (int i = 0; i < 10; i++) bitx(1'b1);
      cs_dn;
      wait_ready(1'b0, "R10 abort");
      rd_chk(2, "R10 aborted word unchanged");

      // R11: activity after a finished read is ignored
      cs_up;
      hdr(2'b10, 1);
      for (int k = 0; k < 17; k++) bitx(1'b0);
      hdr(2'b01, 0);
      send_data(16'h0000);
      chk(do_oe === 1'b0, "R11 post-frame bits ignored", do_oe, 0);
      cs_dn;
      wait_ready(1'b0, "R11 no launch");
      rd_chk(0, "R11 word 0 unchanged");

      // R7: write-all in 16-bit mode
      cs_up;
      hdr(2'b00, ext_addr(2'b01));
      send_data(16'h3C5A);
      cs_dn;
      for (int w = 0; w < NW; w++) mdl_put(w, 16'h3C5A);
      wait_ready(1'b1, "R8 write-all");
      for (int w = 0; w < NW; w++) rd_chk(w, "R7 write-all word");

      // R7/R2: write-all in 8-bit mode
      org = 1'b0;
      cs_up;
      hdr(2'b00, ext_addr(2'b01));
      send_data(16'h0096);
      cs_dn;
      for (int b = 0; b < NB; b++) mdl[b] = 8'h96;
      wait_ready(1'b1, "R8 byte write-all");
      for (int b = 0; b < NB; b += 5) rd_chk(b, "R7 byte write-all");
      org = 1'b1;

      // R6/R3: disable, then erase-all is ignored
      ext_cmd(2'b00);
      wen_m = 1'b0;
      ext_cmd(2'b10);
      wait_ready(1'b0, "R6 erase-all while disabled");
      rd(0, v);
      chk(v === 16'h9696, "R6 contents kept after disabled erase-all", v, 16'h9696);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule